// File: doc/BRIEF.md
# Programmable GPIO Port Controller

This block groups a set of 8-bit general-purpose I/O ports behind a small synchronous register bus. Software sets each pin's direction, writes an output latch and reads back either the live pin level or the latch. A second register type switches pull-ups on for groups of four adjacent pins. The pad itself sits outside the block. The block only supplies digital output value, output enable and pull-up enable signals per pin, and takes in each pin's raw level.

A peripheral can take over any pin as an output through a per-pin override. While it holds the pin, the peripheral's value is driven whatever the direction bit says. Peripherals that use a pin as an input read the synchronized tap. Software leaves that pin's direction at input so that the port does not drive it.

Register map, with P = `NUM_PORTS`: address 2p is the direction register of port p, address 2p+1 is its data register, and addresses 2P and up are the pull-up registers. Every other address is unmapped. Pins are numbered flat, so pin i belongs to port i/8, bit i%8.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset all direction bits, latches and pull-up bits are 0. pin_oe_o, pin_o, pin_pu_o and rdata_o are all 0.
- R2: Writing the direction register of port p (address 2p) sets that port's direction bits. A bit value of 1 selects output and drives pin_oe_o high for that pin. A bit value of 0 selects input.
- R3: Writing the data register of port p (address 2p+1) updates its output latch whatever the direction bits are.
- R4: When no peripheral holds a pin, pin_o carries that pin's latch bit.
- R5: A read of a data register returns, bit by bit, the latch bit for output-mode bits and the synchronized pin level for input-mode bits.
- R6: A change on pin_i shows on pin_sync_o, and in data-register reads, after exactly two rising clock edges.
- R7: Bit g of the pull-up register at address 2P+k covers flat pins 4(8k+g) to 4(8k+g)+3. With 4 ports, bit g of address 8 covers pins 4g to 4g+3. Pull-up registers read back what was written.
- R8: pin_pu_o for a pin is 1 only when its group's pull-up bit is 1 and its direction bit is 0.
- R9: When periph_oe_i is 1 for a pin, pin_oe_o is 1 and pin_o equals periph_out_i, whatever the direction bit and latch hold.
- R10: rdata_o is registered. It shows the register selected by addr_i one clock after the address is presented, with the register's value from before any write made at that same edge.
- R11: Unmapped addresses read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable, applied at the rising edge |
| wdata_i | input | PORT_W | Write data |
| rdata_o | output | PORT_W | Registered read data |
| pin_i | input | NUM_PORTS*PORT_W | Raw pin levels |
| pin_o | output | NUM_PORTS*PORT_W | Value to drive on each pin |
| pin_oe_o | output | NUM_PORTS*PORT_W | Output enable for each pin |
| pin_pu_o | output | NUM_PORTS*PORT_W | Pull-up enable for each pin |
| pin_sync_o | output | NUM_PORTS*PORT_W | Synchronized pin levels for peripheral inputs |
| periph_oe_i | input | NUM_PORTS*PORT_W | Peripheral claims the pin as an output |
| periph_out_i | input | NUM_PORTS*PORT_W | Peripheral output value |

## Verification
The bench targets data reads with mixed directions. A design that muxed the whole byte instead of each bit would return latch bits where pin levels belong. It also writes the latch while pins are inputs, then flips them to outputs. A design that gated latch writes on direction would drive stale data at that point. Pull-up mapping is checked with exact nibble patterns, so an off-by-one group index or a missing direction gate shows up as a wrong mask. Peripheral overrides land on input-mode pins with opposite latch values, unmapped writes are followed by readback of every register, and exact synchronizer latency catches a one- or three-stage chain.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned GRP_W = 4;

  typedef enum logic [1:0] {
    KIND_NONE,
    KIND_DIR,
    KIND_DATA,
    KIND_PU
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [7:0] idx;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input int unsigned a,
                                           input int unsigned nports,
                                           input int unsigned npu);
    reg_sel_t s;
    s.kind = KIND_NONE;
    s.idx  = '0;
    if (a < 2 * nports) begin
      s.kind = (a % 2 == 0) ? KIND_DIR : KIND_DATA;
      s.idx  = 8'(a / 2);
    end else if (a < 2 * nports + npu) begin
      s.kind = KIND_PU;
      s.idx  = 8'(a - 2 * nports);
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;
  logic [1:0]   live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      live_q <= '0;
    end else begin
      s1_q   <= d_i;
      s2_q   <= s1_q;
      live_q <= {live_q[0], 1'b1};
    end
  end

  assign q_o = s2_q;

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q[1] |-> (q_o == $past(d_i, 2))); // R6

endmodule

// File: rtl/gpio_pullup.sv
module gpio_pullup #(
  parameter int unsigned NGRP   = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [7:0]             idx_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [NGRP-1:0]        grp_o,
  output logic [NREG*DATA_W-1:0] rd_o
);

  localparam int unsigned NBITS = NREG * DATA_W;

  logic [NBITS-1:0] pu_q;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    if (b < NGRP) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pu_q[b] <= 1'b0;
        else if (we_i && idx_i == 8'(b / DATA_W)) pu_q[b] <= wdata_i[b % DATA_W];
      end
    end else begin : g_spare
      assign pu_q[b] = 1'b0;
    end
  end

  assign grp_o = pu_q[NGRP-1:0];
  assign rd_o  = pu_q;

  AST_PU_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == 8'd0) |=> (rd_o[DATA_W-1:0] == ($past(wdata_i) & DATA_W'({NBITS{1'b1}} >> (NBITS - NGRP))))); // R7

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dir_we_i,
  input  logic         data_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  input  logic [W-1:0] pu_req_i,
  input  logic [W-1:0] periph_oe_i,
  input  logic [W-1:0] periph_out_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] pin_pu_o
);

  logic [W-1:0] dir_q, latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      latch_q <= '0;
    end else begin
      if (dir_we_i)  dir_q   <= wdata_i;
      if (data_we_i) latch_q <= wdata_i;
    end
  end

  // per-bit source select: latch when driving, pin level when listening
  assign rd_data_o = (dir_q & latch_q) | (~dir_q & pin_sync_i);
  assign pin_oe_o  = dir_q | periph_oe_i;
  assign pin_o     = (periph_oe_i & periph_out_i) | (~periph_oe_i & latch_q);
  assign pin_pu_o  = pu_req_i & ~dir_q;
  assign dir_o     = dir_q;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> (dir_o == $past(wdata_i))); // R2
  AST_LATCH_ANY_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && periph_oe_i == '0) |=> ((pin_o == $past(wdata_i)) || periph_oe_i != '0)); // R3

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [PORT_W-1:0]             wdata_i,
  output logic [PORT_W-1:0]             rdata_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_i,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_pu_o,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_sync_o,
  input  logic [NUM_PORTS*PORT_W-1:0]   periph_oe_i,
  input  logic [NUM_PORTS*PORT_W-1:0]   periph_out_i
);

  localparam int unsigned NPIN   = NUM_PORTS * PORT_W;
  localparam int unsigned NGRP   = NPIN / GRP_W;
  localparam int unsigned NUM_PU = (NGRP + PORT_W - 1) / PORT_W;

  reg_sel_t sel;
  logic [NPIN-1:0]          sync_pins, pu_req, dir_flat, rd_flat;
  logic [NGRP-1:0]          grp_en;
  logic [NUM_PU*PORT_W-1:0] pu_rd;
  logic [PORT_W-1:0]        rd_next;
  logic                     pu_we;

  assign sel   = decode_addr(32'(addr_i), NUM_PORTS, NUM_PU);
  assign pu_we = we_i && sel.kind == KIND_PU;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_pins)
  );
  assign pin_sync_o = sync_pins;

  gpio_pullup #(.NGRP(NGRP), .DATA_W(PORT_W), .NREG(NUM_PU)) u_pullup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pu_we),
    .idx_i  (sel.idx),
    .wdata_i(wdata_i),
    .grp_o  (grp_en),
    .rd_o   (pu_rd)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pu_req[g*GRP_W +: GRP_W] = {GRP_W{grp_en[g]}};
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic dir_we, data_we;
    assign dir_we  = we_i && sel.kind == KIND_DIR  && sel.idx == 8'(p);
    assign data_we = we_i && sel.kind == KIND_DATA && sel.idx == 8'(p);

    gpio_port #(.W(PORT_W)) u_port (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .dir_we_i    (dir_we),
      .data_we_i   (data_we),
      .wdata_i     (wdata_i),
      .pin_sync_i  (sync_pins[p*PORT_W +: PORT_W]),
      .pu_req_i    (pu_req[p*PORT_W +: PORT_W]),
      .periph_oe_i (periph_oe_i[p*PORT_W +: PORT_W]),
      .periph_out_i(periph_out_i[p*PORT_W +: PORT_W]),
      .dir_o       (dir_flat[p*PORT_W +: PORT_W]),
      .rd_data_o   (rd_flat[p*PORT_W +: PORT_W]),
      .pin_o       (pin_o[p*PORT_W +: PORT_W]),
      .pin_oe_o    (pin_oe_o[p*PORT_W +: PORT_W]),
      .pin_pu_o    (pin_pu_o[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_next = '0;
    unique case (sel.kind)
      KIND_DIR: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (sel.idx == 8'(p)) rd_next = dir_flat[p*PORT_W +: PORT_W];
      end
      KIND_DATA: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (sel.idx == 8'(p)) rd_next = rd_flat[p*PORT_W +: PORT_W];
      end
      KIND_PU: begin
        for (int r = 0; r < NUM_PU; r++)
          if (sel.idx == 8'(r)) rd_next = pu_rd[r*PORT_W +: PORT_W];
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_next;
  end

  AST_UNMAPPED_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel.kind == KIND_NONE) |=> (rdata_o == '0)); // R11
  AST_UNMAPPED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel.kind == KIND_NONE) |=> (dir_flat == $past(dir_flat) && pu_rd == $past(pu_rd))); // R11
  AST_PU_INPUT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_pu_o & pin_oe_o & ~periph_oe_i) == '0)); // R8
  AST_PERIPH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((periph_oe_i & ~pin_oe_o) == '0)); // R9
  AST_PERIPH_VAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((periph_oe_i & (pin_o ^ periph_out_i)) == '0)); // R9

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;

  localparam int NP = 4;
  localparam int PW = 8;
  localparam int NPIN = NP * PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      addr = '0;
  logic            we = 1'b0;
  logic [PW-1:0]   wdata = '0;
  logic [PW-1:0]   rdata;
  logic [NPIN-1:0] pin_in = '0, pin_out, pin_oe, pin_pu, pin_sync;
  logic [NPIN-1:0] p_oe = '0, p_out = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe),
    .pin_pu_o(pin_pu), .pin_sync_o(pin_sync), .periph_oe_i(p_oe), .periph_out_i(p_out)
  );

  // behavioural reference
  logic [PW-1:0]   m_dir [NP];
  logic [PW-1:0]   m_lat [NP];
  logic [PW-1:0]   m_pu;
  logic [NPIN-1:0] m_s1, m_s2;
  logic [PW-1:0]   m_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin m_dir[p] = '0; m_lat[p] = '0; end
      m_pu = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      int a;
      a = int'(addr);
      if (a < 2 * NP) begin
        if (a % 2 == 0) m_rd = m_dir[a/2];
        else for (int b = 0; b < PW; b++)
          m_rd[b] = m_dir[a/2][b] ? m_lat[a/2][b] : m_s2[(a/2)*PW + b];
      end else if (a == 2 * NP) m_rd = m_pu;
      else m_rd = '0;
      if (we) begin
        if (a < 2 * NP) begin
          if (a % 2 == 0) m_dir[a/2] = wdata; else m_lat[a/2] = wdata;
        end else if (a == 2 * NP) m_pu = wdata;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [NPIN-1:0] e_oe, e_out, e_pu;
      for (int i = 0; i < NPIN; i++) begin
        e_oe[i]  = p_oe[i] | m_dir[i/PW][i%PW];
        e_out[i] = p_oe[i] ? p_out[i] : m_lat[i/PW][i%PW];
        e_pu[i]  = m_pu[i/4] & ~m_dir[i/PW][i%PW];
      end
      chk(rdata == m_rd, "R5 R10 rdata", 32'(rdata), 32'(m_rd));
      chk(pin_oe == e_oe, "R2 R9 pin_oe", pin_oe, e_oe);
      chk(pin_out == e_out, "R4 R9 pin_o", pin_out, e_out);
      chk(pin_pu == e_pu, "R7 R8 pin_pu", pin_pu, e_pu);
      chk(pin_sync == m_s2, "R6 pin_sync", pin_sync, m_s2);
    end
  end

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic wr(input int a, input logic [PW-1:0] d);
    addr = 4'(a); wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd_expect(input int a, input logic [PW-1:0] exp, input string req);
    addr = 4'(a); we = 1'b0;
    step();
    @(negedge clk); #1;
    chk(rdata == exp, req, 32'(rdata), 32'(exp));
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(pin_oe == '0 && pin_pu == '0 && pin_out == '0 && rdata == '0, "R1 reset", pin_oe | pin_pu | pin_out, 32'h0);
    #4 rst_n = 1'b1;
    step();

    // R7: group 1 covers pins 4..7
    wr(8, 8'h02);
    @(negedge clk); #1;
    chk(pin_pu == 32'h0000_00F0, "R7 group map", pin_pu, 32'h0000_00F0);
    step();
    rd_expect(8, 8'h02, "R7 readback");
    // R8: outputs lose pull-up; R2 direction
    wr(0, 8'h30);
    @(negedge clk); #1;
    chk(pin_pu == 32'h0000_00C0, "R8 dir gate", pin_pu, 32'h0000_00C0);
    chk(pin_oe == 32'h0000_0030, "R2 oe", pin_oe, 32'h0000_0030);
    step();
    // R3: latch written while input, R4 visible once output
    wr(3, 8'h5A);
    wr(2, 8'hFF);
    @(negedge clk); #1;
    chk(pin_out[15:8] == 8'h5A && pin_oe[15:8] == 8'hFF, "R3 R4 latch", 32'(pin_out[15:8]), 32'h5A);
    step();
    // R6: two-edge synchronizer on port 2
    pin_in[23:16] = 8'hA5;
    @(posedge clk); @(negedge clk); #1;
    chk(pin_sync[23:16] == 8'h00, "R6 one edge", 32'(pin_sync[23:16]), 32'h0);
    @(posedge clk); @(negedge clk); #1;
    chk(pin_sync[23:16] == 8'hA5, "R6 two edges", 32'(pin_sync[23:16]), 32'hA5);
    step();
    // R5: mixed direction read on port 2
    wr(4, 8'h0F);
    wr(5, 8'h33);
    rd_expect(5, 8'hA3, "R5 mixed read");
    // R10: same-edge write shows old value
    addr = 4'd4; wdata = 8'hC3; we = 1'b1;
    step(); we = 1'b0;
    @(negedge clk); #1;
    chk(rdata == 8'h0F, "R10 old value", 32'(rdata), 32'h0F);
    step();
    rd_expect(4, 8'hC3, "R10 new value");
    // R9: peripheral override on input pin with latch 0
    p_oe = 32'h8000_0000; p_out = 32'h8000_0000;
    @(negedge clk); #1;
    chk(pin_oe[31] && pin_out[31], "R9 override", {pin_oe[31], pin_out[31]}, 32'h3);
    step();
    p_oe = '0;
    // R11: unmapped write ignored, reads zero
    wr(12, 8'hFF);
    wr(9, 8'hFF);
    rd_expect(12, 8'h00, "R11 unmapped read");
    rd_expect(8, 8'h02, "R11 pullup intact");
    rd_expect(0, 8'h30, "R11 dir intact");

    // random traffic checked by the reference every cycle
    for (int n = 0; n < 600; n++) begin
      addr  = 4'($urandom_range(0, 15));
      we    = 1'($urandom_range(0, 1));
      wdata = 8'($urandom);
      pin_in = $urandom;
      p_oe  = $urandom & $urandom & $urandom;
      p_out = $urandom;
      step();
    end
    we = 1'b0;
    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule